// File: doc/BRIEF.md
# Matrix Least-Recently-Used Tracker

This block keeps the exact recency order of a small set of entries, such as the frames of a page pool or the ways of a translation buffer set. It stores that order as a square bit matrix with one row and one column per entry. Each reference to an entry is one strobe plus an index. In a single clock the block fills that entry's row with ones and then clears its column. When a row is read as a binary number, a higher value means a more recent entry.

Two indices come out combinationally from the registered matrix. One is the least recently used entry, which is the victim choice. The other is the most recently used entry. Both reflect every reference made up to and including the previous clock edge. Reset clears the matrix. All rows are then equal, and ties go to the lowest index.

Top module: `lru_matrix_tracker`

## Requirements
- R1: After reset both `lruIdx` and `mruIdx` read 0.
- R2: A reference to entry k with `refValid` high changes the state at the next clock edge, and from then on `mruIdx` reads k.
- R3: When there is more than one entry, the entry just referenced is never `lruIdx` in the cycle after its reference.
- R4: A cycle with `refValid` low changes neither output, whatever `refIdx` holds.
- R5: `lruIdx` names the entry whose latest reference is oldest. Entries never referenced since reset count as older than every referenced entry, and equal rank resolves to the lowest index.
- R6: Row k is read as a number with column 0 as its most significant bit. The row with the smallest value is `lruIdx` and the row with the largest value is `mruIdx`, ties to the lowest index.
- R7: With 4 entries, the reference sequence 0,1,2,3,2,1,0,3,2,3 gives, after each step, (LRU, MRU) of (1,0) (2,1) (3,2) (0,3) (0,2) (0,1) (3,0) (2,3) (1,2) (1,3).
- R8: Referencing the entry that is already most recent leaves both outputs unchanged.
- R9: Asserting reset in the middle of operation returns both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| refValid | input | 1 | Reference strobe |
| refIdx | input | $clog2(N) | Index of the referenced entry |
| lruIdx | output | $clog2(N) | Least recently used entry |
| mruIdx | output | $clog2(N) | Most recently used entry |

## Verification
The bench builds the tracker with N = 4. At that size the prescribed ten-step sequence can be checked exactly, and a pseudo-random walk of several hundred references visits many of the 24 possible recency orders. Because 4 is a power of two, the selection trees carry no padding leaves. The bench compares against a timestamp model with lowest-index tie-breaking, so rows that are still equal after reset or after a partial fill test the tie logic directly.

// File: rtl/lru_pkg.sv
package lru_pkg;
  // Strobes from the reference decoder to the matrix datapath
  typedef struct packed {
    logic update;   // write one row and one column this cycle
    logic idle;     // matrix holds its value
  } lruStrobe_t;
endpackage

// File: rtl/lru_ctrl.sv
module lru_ctrl #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  refValid,
  input  logic [IW-1:0]         refIdx,
  output lru_pkg::lruStrobe_t   strobe,
  output logic [N-1:0]          refSel
);
  always_comb begin
    strobe.update = refValid;
    strobe.idle   = !refValid;
    refSel        = '0;
    if (refValid) refSel = N'(1) << refIdx;
  end

  // R2: an update selects exactly one row/column
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.update |-> $countones(refSel) == 1);
  // R4: no selection when idle
  p_idle_nosel_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.idle |-> refSel == '0);
endmodule

// File: rtl/lru_matrix_dp.sv
module lru_matrix_dp #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lru_pkg::lruStrobe_t  strobe,
  input  logic [N-1:0]         refSel,
  output logic [N*N-1:0]       rowVals
);
  logic [N-1:0] mat [N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < N; r++) mat[r] <= '0;
    end else if (strobe.update) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          if (refSel[c])      mat[r][c] <= 1'b0;   // column clear wins
          else if (refSel[r]) mat[r][c] <= 1'b1;   // row set
    end
  end

  // Column 0 is the most significant bit of each row value
  always_comb begin
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        rowVals[r*N + (N-1-c)] = mat[r][c];
  end

  // R6: diagonal stays clear, so a row never counts itself
  for (genvar d = 0; d < N; d++) begin : g_diag
    p_diag_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
      strobe.update && refSel[d] |=> !mat[d][d]);
  end
endmodule

// File: rtl/lru_pick_tree.sv
module lru_pick_tree #(
  parameter int N = 4,
  parameter bit FIND_MAX = 1'b0,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int P = 1 << IW,
  localparam int NODES = 2*P - 1
) (
  input  logic [N*N-1:0] vals,
  output logic [IW-1:0]  pickIdx
);
  logic [N-1:0]  nVal [NODES];
  logic [IW-1:0] nIdx [NODES];
  logic          nVld [NODES];

  for (genvar j = 0; j < P; j++) begin : g_leaf
    if (j < N) begin : g_real
      assign nVal[P-1+j] = vals[j*N +: N];
      assign nIdx[P-1+j] = IW'(j);
      assign nVld[P-1+j] = 1'b1;
    end else begin : g_pad
      assign nVal[P-1+j] = '0;
      assign nIdx[P-1+j] = '0;
      assign nVld[P-1+j] = 1'b0;
    end
  end

  // Left subtree holds lower indices, so ties keep the left child
  for (genvar i = 0; i < P-1; i++) begin : g_node
    logic takeRight;
    if (FIND_MAX) begin : g_max
      assign takeRight = nVld[2*i+2] &&
                         (!nVld[2*i+1] || nVal[2*i+2] > nVal[2*i+1]);
    end else begin : g_min
      assign takeRight = nVld[2*i+2] &&
                         (!nVld[2*i+1] || nVal[2*i+2] < nVal[2*i+1]);
    end
    assign nVal[i] = takeRight ? nVal[2*i+2] : nVal[2*i+1];
    assign nIdx[i] = takeRight ? nIdx[2*i+2] : nIdx[2*i+1];
    assign nVld[i] = nVld[2*i+1] || nVld[2*i+2];
  end

  assign pickIdx = nIdx[0];
endmodule

// File: rtl/lru_matrix_tracker.sv
module lru_matrix_tracker #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          refValid,
  input  logic [IW-1:0] refIdx,
  output logic [IW-1:0] lruIdx,
  output logic [IW-1:0] mruIdx
);
  lru_pkg::lruStrobe_t strobe;
  logic [N-1:0]        refSel;
  logic [N*N-1:0]      rowVals;

  lru_ctrl #(.N(N)) uCtrl (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refIdx(refIdx),
    .strobe(strobe), .refSel(refSel)
  );

  lru_matrix_dp #(.N(N)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .refSel(refSel),
    .rowVals(rowVals)
  );

  lru_pick_tree #(.N(N), .FIND_MAX(1'b0)) uMin (.vals(rowVals), .pickIdx(lruIdx));
  lru_pick_tree #(.N(N), .FIND_MAX(1'b1)) uMax (.vals(rowVals), .pickIdx(mruIdx));

  // R2: the referenced entry becomes the most recent next cycle
  p_mru_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    refValid |=> mruIdx == $past(refIdx));

  // R3: the referenced entry is not the victim next cycle
  if (N > 1) begin : g_multi
    p_lru_not_ref_r3: assert property (@(posedge clk) disable iff (!rstN)
      refValid |=> lruIdx != $past(refIdx));
  end

  // R4: no reference, no change
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !refValid |=> $stable(lruIdx) && $stable(mruIdx));
endmodule

// File: tb/tb_lru_matrix_tracker.sv
module tb_lru_matrix_tracker;
  localparam int N = 4;
  localparam int IW = 2;
  localparam time PERIOD = 10ns;

  // {refIdx, expected lru, expected mru} for the R7 sequence
  localparam logic [5:0] SEQ_VEC [10] = '{
    6'b00_01_00, 6'b01_10_01, 6'b10_11_10, 6'b11_00_11, 6'b10_00_10,
    6'b01_00_01, 6'b00_11_00, 6'b11_10_11, 6'b10_01_10, 6'b11_01_11
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          refValid = 1'b0;
  logic [IW-1:0] refIdx = '0;
  logic [IW-1:0] lruIdx, mruIdx;

  int nChecks = 0;
  int nFails = 0;
  int stamp [N];
  int tick = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  lru_matrix_tracker #(.N(N)) dut (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refIdx(refIdx),
    .lruIdx(lruIdx), .mruIdx(mruIdx)
  );

  task automatic check(input string req, input logic [IW-1:0] act,
                       input logic [IW-1:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < N; i++) stamp[i] = -1;
    tick = 0;
  endtask

  function automatic logic [IW-1:0] modelLru();
    int best = 0;
    for (int i = 1; i < N; i++) if (stamp[i] < stamp[best]) best = i;
    return IW'(best);
  endfunction

  function automatic logic [IW-1:0] modelMru();
    int best = 0;
    for (int i = 1; i < N; i++) if (stamp[i] > stamp[best]) best = i;
    return IW'(best);
  endfunction

  // drive on the falling edge, state updates on the rising edge, sample on the next falling edge
  task automatic step(input logic v, input logic [IW-1:0] idx);
    @(negedge clk);
    refValid = v;
    refIdx = idx;
    @(negedge clk);
    refValid = 1'b0;
    if (v) begin
      stamp[idx] = tick;
      tick++;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] keepL, keepM;
    logic [31:0] lfsr;
    modelReset();
    doReset();
    check("R1", lruIdx, '0, "lru after reset");
    check("R1", mruIdx, '0, "mru after reset");

    // R7 vector table
    for (int s = 0; s < 10; s++) begin
      step(1'b1, SEQ_VEC[s][5:4]);
      check("R7", lruIdx, SEQ_VEC[s][3:2], "lru in sequence");
      check("R7", mruIdx, SEQ_VEC[s][1:0], "mru in sequence");
    end

    // R4: idle cycles with a wandering index
    keepL = lruIdx; keepM = mruIdx;
    for (int i = 0; i < N; i++) begin
      step(1'b0, IW'(i));
      check("R4", lruIdx, keepL, "lru while idle");
      check("R4", mruIdx, keepM, "mru while idle");
    end

    // R8: re-reference the most recent entry
    step(1'b1, mruIdx);
    check("R8", lruIdx, keepL, "lru after repeat");
    check("R8", mruIdx, keepM, "mru after repeat");

    // R9: mid-run reset
    doReset();
    check("R9", lruIdx, '0, "lru after mid reset");
    check("R9", mruIdx, '0, "mru after mid reset");

    // R5 partial fill: unreferenced entries are older, lowest index wins
    step(1'b1, 2'd2);
    check("R5", lruIdx, 2'd0, "lru partial fill");
    check("R2", mruIdx, 2'd2, "mru partial fill");
    step(1'b1, 2'd0);
    check("R5", lruIdx, 2'd1, "lru partial fill 2");
    check("R3", mruIdx, 2'd0, "mru partial fill 2");

    // R5/R6 pseudo-random walk against the timestamp model
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[5] | lfsr[9], lfsr[IW-1:0]);
      check("R5", lruIdx, modelLru(), "lru random walk");
      check("R6", mruIdx, modelMru(), "mru random walk");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule